// File: doc/BRIEF.md
# Link Block Packer

This block collects the packets of one logical link and repacks them into fixed-size blocks that can be moved to host memory in bulk. Packets arrive as a stream of 16-bit words with start, end and error markers. Blocks leave as a stream of 32-bit words, and the final word of each block is flagged. Each block opens with a one-word header that names the link and counts blocks. The rest of the block holds sub-chunks. A sub-chunk is a run of packet data followed by a 16-bit trailer that gives its type, its flags and its length.

A packet is cut wherever a block boundary falls, and it carries on in the next block. Each piece of a packet is typed according to its place in the packet. When the link goes quiet, a programmable timeout closes a block that is only partly filled. The unused space is filled with zeros and ends in a trailer of type null. When the output stalls, the input stalls with it, so no word is ever lost.

Top module: `link_block_packer`

## Requirements
- R1: The first 32-bit word of every block carries the start-of-block symbol (parameter, default 16'hABCD) in bits [15:0], the link ID in bits [31:21] and the 5-bit block sequence number in bits [20:16].
- R2: A packet that fits in the space left in the current block forms one sub-chunk: its data halfwords, followed by a trailer of type both (3'b011).
- R3: If only one halfword slot is left in a block while a packet is open, that slot takes a trailer of type first (3'b001) or middle (3'b100), and the block closes. The packet continues in the next block, and its final piece is typed last (3'b010).
- R4: A trailer is the 16-bit word directly after its data. Bits [15:13] hold the type, bit 12 the transfer-error flag, bit 11 the truncation flag and bits [10:9] are zero. Bits [8:0] hold the number of 16-bit data words in the sub-chunk, not counting the trailer.
- R5: If the block is open and the input is idle for the programmed number of consecutive cycles, the open piece of any packet is closed with a first or middle trailer. Zero halfwords then fill the block up to its last slot, and that slot takes a null trailer (3'b000) whose length is the number of zero halfwords. Every accepted input word restarts the count.
- R6: A packet whose end word also carries the error marker has bit 12 set in its final trailer. Other packets have bit 12 clear.
- R7: A start marker that arrives while a packet is still open first closes the open packet with a last or both trailer that has bit 11 set. The marked word then begins a new packet.
- R8: While the output is not ready, the output word and its flags stay stable. The input is stalled rather than dropped, and word order is preserved.
- R9: The sequence number is 0 in the first block after reset, goes up by one for each block and wraps from 31 to 0.
- R10: If exactly one slot is left in a block and no packet is open, that slot takes a null trailer of length 0, and the block closes.
- R11: In each output word, the even halfword slot of the block is in bits [15:0] and the odd slot is in bits [31:16]. The last-word flag is set exactly on the final word of each block.
- R12: Out of reset, the input is not ready and no output is valid. A timeout limit of 0 disables the timeout.
- R13: A word without a start marker that arrives while no packet is open begins a new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_link_id | input | 11 | Link ID placed in each header |
| i_tmo_limit | input | TMO_W | Idle cycles before a partial block is flushed; 0 disables the timeout |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted when high together with s_valid |
| s_data | input | 16 | Input packet word |
| s_sop | input | 1 | Word starts a packet |
| s_eop | input | 1 | Word ends a packet |
| s_err | input | 1 | Error marker, taken from the end word |
| m_valid | output | 1 | Output block word valid |
| m_ready | input | 1 | Downstream can take a word |
| m_data | output | 32 | Output block word |
| m_last | output | 1 | Final word of a block |

## Verification
The bench targets the slot just before a block boundary. A design that miscounted there would let a data word take the reserved trailer slot, or would leave a lone free slot without a null trailer. Packets longer than several blocks check the first, middle and last types and the per-piece lengths. A timeout in the middle of a packet checks that the block is padded without losing the packet's place. A start marker that arrives inside a packet must raise the truncation flag rather than merge two packets. Random output back-pressure and more than 32 blocks in total catch words that are dropped or repeated, and a sequence number that fails to wrap.

// File: rtl/blkpk_pkg.sv
package blkpk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR0,
        ST_HDR1,
        ST_FILL,
        ST_TRL,
        ST_PAD
    } fill_st_e;

    typedef enum logic [2:0] {
        SC_NULL   = 3'd0,
        SC_FIRST  = 3'd1,
        SC_LAST   = 3'd2,
        SC_BOTH   = 3'd3,
        SC_MIDDLE = 3'd4
    } sc_kind_e;

    localparam int LINK_ID_W = 11;
    localparam int SEQ_W     = 5;
    localparam int LEN_W     = 9;

    function automatic sc_kind_e cont_kind(logic first);
        return first ? SC_FIRST : SC_MIDDLE;
    endfunction

    function automatic sc_kind_e end_kind(logic first);
        return first ? SC_BOTH : SC_LAST;
    endfunction

    function automatic logic [15:0] make_trailer(sc_kind_e k, logic xerr, logic trunc,
                                                 logic [LEN_W-1:0] len);
        return {k, xerr, trunc, 2'b00, len};
    endfunction

endpackage

// File: rtl/blkpk_timeout.sv
module blkpk_timeout #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             idle,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (idle && (cnt_q < limit)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (limit != '0) && (cnt_q >= limit);

    // R5
    tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !expired);

endmodule

// File: rtl/blkpk_pair.sv
module blkpk_pair #(
    parameter int WORDS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hw_valid,
    input  logic [15:0] hw_data,
    input  logic        hw_odd,
    input  logic        hw_end,
    output logic        hw_ready,
    output logic        o_valid,
    output logic [31:0] o_data,
    output logic        o_last,
    input  logic        o_ready
);

    localparam int WC_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    typedef struct packed {
        logic [15:0] lo;
        logic        ov;
        logic [31:0] od;
        logic        ol;
    } pair_s;

    pair_s d, q;

    always_comb begin
        d = q;
        if (q.ov && o_ready) d.ov = 1'b0;
        hw_ready = !hw_odd || !q.ov || o_ready;
        if (hw_valid && hw_ready) begin
            if (!hw_odd) begin
                d.lo = hw_data;
            end else begin
                d.ov = 1'b1;
                d.od = {hw_data, q.lo};
                d.ol = hw_end;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign o_valid = q.ov;
    assign o_data  = q.od;
    assign o_last  = q.ol;

    // checker state: output words handed over within the current block
    logic [WC_W-1:0] wcnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (o_valid && o_ready) begin
            wcnt_q <= (wcnt_q == WC_W'(WORDS-1)) ? '0 : wcnt_q + 1'b1;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_last)));

    // R11
    last_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> (o_last == (wcnt_q == WC_W'(WORDS-1))));

endmodule

// File: rtl/blkpk_fill.sv
module blkpk_fill
    import blkpk_pkg::*;
#(
    parameter int          SLOTS = 512,
    parameter logic [15:0] SOB   = 16'hABCD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINK_ID_W-1:0] link_id,
    input  logic                 i_valid,
    output logic                 i_ready,
    input  logic [15:0]          i_data,
    input  logic                 i_sop,
    input  logic                 i_eop,
    input  logic                 i_err,
    input  logic                 tmo_expired,
    output logic                 tmo_clr,
    output logic                 hw_valid,
    output logic [15:0]          hw_data,
    output logic                 hw_odd,
    output logic                 hw_end,
    input  logic                 hw_ready
);

    localparam int SLOT_W = $clog2(SLOTS);

    typedef struct packed {
        fill_st_e          st;
        logic [SLOT_W-1:0] slot;
        logic [SEQ_W-1:0]  seq;
        logic              in_pkt;
        logic              first;
        logic [LEN_W-1:0]  len;
        logic              err;
    } fill_s;

    fill_s d, q;
    logic  rem1;
    logic  accept;
    logic  hw_is_trl;
    logic  newp;

    assign rem1 = (q.slot == SLOT_W'(SLOTS-1));

    always_comb begin
        d         = q;
        hw_valid  = 1'b0;
        hw_data   = '0;
        hw_is_trl = 1'b0;
        i_ready   = 1'b0;
        accept    = 1'b0;
        newp      = !q.in_pkt || i_sop;
        case (q.st)
            ST_IDLE: begin
                if (i_valid) d.st = ST_HDR0;
            end
            ST_HDR0: begin
                hw_valid = 1'b1;
                hw_data  = SOB;
                if (hw_ready) d.st = ST_HDR1;
            end
            ST_HDR1: begin
                hw_valid = 1'b1;
                hw_data  = {link_id, q.seq};
                if (hw_ready) begin
                    d.st  = ST_FILL;
                    d.seq = q.seq + 1'b1;
                end
            end
            ST_FILL: begin
                if (rem1) begin
                    hw_valid  = 1'b1;
                    hw_is_trl = 1'b1;
                    hw_data   = q.in_pkt ? make_trailer(cont_kind(q.first), 1'b0, 1'b0, q.len)
                                         : make_trailer(SC_NULL, 1'b0, 1'b0, '0);
                    if (hw_ready) begin
                        d.first = 1'b0;
                        d.len   = '0;
                        d.st    = ST_IDLE;
                    end
                end else if (i_valid && i_sop && q.in_pkt) begin
                    hw_valid  = 1'b1;
                    hw_is_trl = 1'b1;
                    hw_data   = make_trailer(end_kind(q.first), 1'b0, 1'b1, q.len);
                    if (hw_ready) begin
                        d.in_pkt = 1'b0;
                        d.len    = '0;
                    end
                end else if (i_valid) begin
                    hw_valid = 1'b1;
                    hw_data  = i_data;
                    i_ready  = hw_ready;
                    if (hw_ready) begin
                        accept   = 1'b1;
                        d.in_pkt = 1'b1;
                        d.first  = newp ? 1'b1 : q.first;
                        d.len    = newp ? LEN_W'(1) : q.len + 1'b1;
                        if (i_eop) begin
                            d.st  = ST_TRL;
                            d.err = i_err;
                        end
                    end
                end else if (tmo_expired) begin
                    if (q.in_pkt && (q.len != '0)) begin
                        hw_valid  = 1'b1;
                        hw_is_trl = 1'b1;
                        hw_data   = make_trailer(cont_kind(q.first), 1'b0, 1'b0, q.len);
                        if (hw_ready) begin
                            d.first = 1'b0;
                            d.len   = '0;
                            d.st    = ST_PAD;
                        end
                    end else begin
                        d.len = '0;
                        d.st  = ST_PAD;
                    end
                end
            end
            ST_TRL: begin
                hw_valid  = 1'b1;
                hw_is_trl = 1'b1;
                hw_data   = make_trailer(end_kind(q.first), q.err, 1'b0, q.len);
                if (hw_ready) begin
                    d.in_pkt = 1'b0;
                    d.len    = '0;
                    d.err    = 1'b0;
                    d.st     = rem1 ? ST_IDLE : ST_FILL;
                end
            end
            ST_PAD: begin
                hw_valid = 1'b1;
                if (rem1) begin
                    hw_is_trl = 1'b1;
                    hw_data   = make_trailer(SC_NULL, 1'b0, 1'b0, q.len);
                    if (hw_ready) begin
                        d.len = '0;
                        d.st  = ST_IDLE;
                    end
                end else begin
                    hw_data = '0;
                    if (hw_ready) d.len = q.len + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (hw_valid && hw_ready) begin
            d.slot = rem1 ? '0 : q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign hw_odd  = q.slot[0];
    assign hw_end  = rem1;
    assign tmo_clr = (q.st != ST_FILL) || accept;

    // R4
    trl_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_valid && hw_is_trl) |-> (hw_data[LEN_W-1:0] <= LEN_W'(SLOTS-3)));

    // R3
    trl_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_valid && hw_end) |-> hw_is_trl);

endmodule

// File: rtl/link_block_packer.sv
module link_block_packer
    import blkpk_pkg::*;
#(
    parameter int          BLOCK_BYTES = 1024,
    parameter int          TMO_W       = 16,
    parameter logic [15:0] SOB         = 16'hABCD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINK_ID_W-1:0] i_link_id,
    input  logic [TMO_W-1:0]     i_tmo_limit,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic [15:0]          s_data,
    input  logic                 s_sop,
    input  logic                 s_eop,
    input  logic                 s_err,
    output logic                 m_valid,
    input  logic                 m_ready,
    output logic [31:0]          m_data,
    output logic                 m_last
);

    localparam int SLOTS = BLOCK_BYTES / 2;
    localparam int WORDS = BLOCK_BYTES / 4;

    initial begin
        blk_size_chk: assert (BLOCK_BYTES % 4 == 0 && BLOCK_BYTES >= 16 && SLOTS - 3 < 512);
    end

    logic        hw_valid, hw_ready, hw_odd, hw_end;
    logic [15:0] hw_data;
    logic        tmo_clr, tmo_expired;

    blkpk_timeout #(.TMO_W(TMO_W)) i_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmo_clr),
        .idle    (!s_valid),
        .limit   (i_tmo_limit),
        .expired (tmo_expired)
    );

    blkpk_fill #(.SLOTS(SLOTS), .SOB(SOB)) i_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_id     (i_link_id),
        .i_valid     (s_valid),
        .i_ready     (s_ready),
        .i_data      (s_data),
        .i_sop       (s_sop),
        .i_eop       (s_eop),
        .i_err       (s_err),
        .tmo_expired (tmo_expired),
        .tmo_clr     (tmo_clr),
        .hw_valid    (hw_valid),
        .hw_data     (hw_data),
        .hw_odd      (hw_odd),
        .hw_end      (hw_end),
        .hw_ready    (hw_ready)
    );

    blkpk_pair #(.WORDS(WORDS)) i_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_valid (hw_valid),
        .hw_data  (hw_data),
        .hw_odd   (hw_odd),
        .hw_end   (hw_end),
        .hw_ready (hw_ready),
        .o_valid  (m_valid),
        .o_data   (m_data),
        .o_last   (m_last),
        .o_ready  (m_ready)
    );

endmodule

// File: tb/test_link_block_packer.sv
module test_link_block_packer;

    localparam int          BLOCK_BYTES = 32;
    localparam int          SLOTS       = BLOCK_BYTES / 2;
    localparam int          WORDS       = BLOCK_BYTES / 4;
    localparam logic [15:0] SOB         = 16'hABCD;
    localparam logic [10:0] LINK        = 11'h5A3;
    localparam int          LIMIT       = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmo_limit = 16'(LIMIT);
    logic        s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0, s_err = 1'b0;
    logic [15:0] s_data = '0;
    logic        s_ready;
    logic        m_valid, m_last;
    logic [31:0] m_data;
    logic        m_ready = 1'b1;
    logic        bp_mode = 1'b0;

    int total = 0;
    int bad   = 0;

    logic [15:0] exp_q[$];
    logic [32:0] rx_q[$];

    int m_slot = 0, m_len = 0, m_seq = 0;
    bit m_inpkt = 0, m_first = 0;

    link_block_packer #(.BLOCK_BYTES(BLOCK_BYTES), .TMO_W(16), .SOB(SOB)) i_link_block_packer (
        .clk(clk), .rst_n(rst_n), .i_link_id(LINK), .i_tmo_limit(tmo_limit),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sop(s_sop),
        .s_eop(s_eop), .s_err(s_err), .m_valid(m_valid), .m_ready(m_ready),
        .m_data(m_data), .m_last(m_last)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        #1;
        m_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (rst_n && m_valid && m_ready) rx_q.push_back({m_last, m_data});
    end

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // ---------------- reference model of the block layout ----------------
    function automatic logic [15:0] trl(int k, bit e, bit t, int len);
        return {3'(k), e, t, 2'b00, 9'(len)};
    endfunction

    task automatic m_put(logic [15:0] h);
        exp_q.push_back(h);
        m_slot++;
        if (m_slot == SLOTS) m_slot = 0;
    endtask

    task automatic m_settle();
        if (m_slot == SLOTS - 1) begin
            if (m_inpkt) m_put(trl(m_first ? 1 : 4, 0, 0, m_len));
            else         m_put(trl(0, 0, 0, 0));
            if (m_inpkt) m_first = 0;
            m_len = 0;
        end
    endtask

    task automatic m_open();
        if (m_slot == 0) begin
            m_put(SOB);
            m_put({LINK, 5'(m_seq)});
            m_seq = (m_seq + 1) % 32;
        end
    endtask

    task automatic m_word(logic [15:0] w, bit sop, bit eop, bit err);
        m_open();
        if (sop && m_inpkt) begin
            m_put(trl(m_first ? 3 : 2, 0, 1, m_len));
            m_inpkt = 0;
            m_len = 0;
            m_settle();
            m_open();
        end
        if (!m_inpkt || sop) begin
            m_inpkt = 1;
            m_first = 1;
            m_len = 0;
        end
        m_put(w);
        m_len++;
        if (eop) begin
            m_put(trl(m_first ? 3 : 2, err, 0, m_len));
            m_inpkt = 0;
            m_len = 0;
        end
        m_settle();
    endtask

    task automatic m_flush();
        int pad = 0;
        if (m_slot != 0) begin
            if (m_inpkt && m_len > 0) begin
                m_put(trl(m_first ? 1 : 4, 0, 0, m_len));
                m_first = 0;
                m_len = 0;
            end
            while (m_slot != SLOTS - 1) begin
                m_put(16'h0000);
                pad++;
            end
            m_put(trl(0, 0, 0, pad));
        end
    endtask

    // ---------------- drivers ----------------
    task automatic drive(logic [15:0] w, bit sop, bit eop, bit err);
        m_word(w, sop, eop, err);
        s_data = w; s_sop = sop; s_eop = eop; s_err = err; s_valid = 1'b1;
        @(negedge clk);
        while (!s_ready) @(negedge clk);
        @(posedge clk);
        #1;
        s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0; s_err = 1'b0;
    endtask

    task automatic send_pkt(int n, int base, bit err, bit with_sop, bit with_eop);
        for (int i = 0; i < n; i++) begin
            drive(16'(base + i), with_sop && (i == 0), with_eop && (i == n - 1),
                  err && (i == n - 1));
        end
    endtask

    task automatic check_blocks(string tag);
        int waitc = 0;
        m_flush();
        while ((rx_q.size() * 2 < exp_q.size()) && (waitc < 4000)) begin
            @(negedge clk);
            waitc++;
        end
        repeat (LIMIT + 30) @(negedge clk);
        chk(rx_q.size() * 2 == exp_q.size(), tag, "word count", rx_q.size(), exp_q.size() / 2);
        for (int i = 0; (i < rx_q.size()) && (2 * i + 1 < exp_q.size()); i++) begin
            logic [31:0] ew;
            logic        el;
            ew = {exp_q[2*i+1], exp_q[2*i]};
            el = ((i % WORDS) == WORDS - 1);
            chk(rx_q[i][31:0] == ew, tag, ((i % WORDS) == 0) ? "R1 header" : "R4 body word",
                rx_q[i][31:0], ew);
            chk(rx_q[i][32] == el, tag, "R11 last flag", rx_q[i][32], el);
        end
        exp_q.delete();
        rx_q.delete();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(s_ready == 1'b0, "R12", "ready in reset", s_ready, 0);
        chk(m_valid == 1'b0, "R12", "valid in reset", m_valid, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(s_ready == 1'b0 && m_valid == 1'b0, "R12", "idle after reset",
            {s_ready, m_valid}, 0);
        @(posedge clk); #1;
    endtask

    task automatic t_both();
        tmo_limit = '0;
        send_pkt(3, 16'h100, 0, 1, 1);
        repeat (100) @(negedge clk);
        chk(rx_q.size() == exp_q.size() / 2, "R12", "no flush with limit 0",
            rx_q.size(), exp_q.size() / 2);
        @(posedge clk); #1 tmo_limit = 16'(LIMIT);
        check_blocks("R2 R5");
    endtask

    task automatic t_split();
        send_pkt(30, 16'h200, 0, 1, 1);
        check_blocks("R3");
    endtask

    task automatic t_err();
        send_pkt(4, 16'h300, 1, 1, 1);
        send_pkt(2, 16'h310, 0, 1, 1);
        check_blocks("R6");
    endtask

    task automatic t_trunc();
        send_pkt(3, 16'h400, 0, 1, 0);
        send_pkt(2, 16'h410, 0, 1, 1);
        check_blocks("R7");
    endtask

    task automatic t_nosop();
        send_pkt(3, 16'h500, 0, 0, 1);
        send_pkt(2, 16'h510, 0, 0, 1);
        check_blocks("R13");
    endtask

    task automatic t_onefree();
        send_pkt(12, 16'h600, 0, 1, 1);
        send_pkt(12, 16'h620, 0, 1, 1);
        check_blocks("R10");
    endtask

    task automatic t_tmo_mid();
        send_pkt(5, 16'h700, 0, 1, 0);
        repeat (LIMIT + 40) @(negedge clk);
        m_flush();
        @(posedge clk); #1;
        send_pkt(2, 16'h710, 0, 0, 1);
        check_blocks("R5");
    endtask

    task automatic t_bp();
        bp_mode = 1'b1;
        send_pkt(7, 16'h800, 0, 1, 1);
        send_pkt(20, 16'h820, 1, 1, 1);
        send_pkt(1, 16'h840, 0, 1, 1);
        send_pkt(13, 16'h850, 0, 1, 1);
        check_blocks("R8");
        bp_mode = 1'b0;
    endtask

    task automatic t_wrap();
        for (int p = 0; p < 10; p++) send_pkt(50, 16'h1000 + p * 64, 0, 1, 1);
        check_blocks("R9");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_both();
        t_split();
        t_err();
        t_trunc();
        t_nosop();
        t_onefree();
        t_tmo_mid();
        t_bp();
        t_wrap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule